// File: doc/BRIEF.md
# Compare-Driven Waveform Timer Channel

This block is a single up-counting timer channel that turns a master clock into a periodic pulse or PWM waveform. A selectable prescaler slows the count. The counter runs from zero up to a programmed period limit and then returns to zero. Two compare values, a duty point and the period limit, each fire a programmable action on the waveform output: nothing, drive high, drive low or invert. A common setup drives the output low at the duty point and high at the period limit, which gives a PWM signal whose high time is set by the duty point.

Each compare hit also produces a one-clock event pulse. A neighbouring converter or sampler can use these pulses as a conversion trigger. Software reaches the channel through a small write port. It uses this port to program the two compare values and the two actions, to start or stop the count, and to issue a restart. A restart input shared by several channels lets them all restart on the same edge, so their outputs stay phase-aligned.

Top module: `cmp_wave_timer`

## Requirements
- R1: After reset the waveform output is 0, both event outputs are 0, counting is stopped, both compare values are 0 and both actions are none. Without an enable command, no event occurs and the output does not change.
- R2: While running, the count advances by one on each prescaler tick. On a tick where the count equals the period value, the count returns to 0 and `periodEvt` is high for exactly the following clock cycle. Starting from 0, the period is (period value + 1) ticks.
- R3: On a tick where the count equals the duty value, `dutyEvt` is high for exactly the following clock cycle. If the duty value is greater than the period value, `dutyEvt` never fires.
- R4: Each 2-bit action code changes `waveOut` on its compare hit: 00 leaves it unchanged, 01 drives it to 1, 10 drives it to 0 and 11 inverts it. The change appears in the same cycle as the matching event pulse.
- R5: If the duty and period compares hit on the same tick, only the period action is applied. Both event pulses still fire.
- R6: `clkSel` sets the tick rate: 0 gives every clock, 1 gives every 2nd clock, 2 gives every 8th clock and 3 gives every 32nd clock. After a restart, the first tick falls on the clock edge N clocks after the restart edge, where N is the divide ratio.
- R7: A restart command sets the count and the prescaler phase to 0 on its own edge and does not change `waveOut`. Counting then continues only if the channel is enabled. A restart while the channel is stopped produces no events.
- R8: A high `syncIn` on a clock edge has the same effect as the restart command.
- R9: The disable command stops counting from its own edge and holds the count and `waveOut`. The enable command resumes counting from the held count starting on its own edge. If both are written together, disable wins.
- R10: The write port decodes `wrAddr` as follows. Address 0 holds the actions: bits [1:0] are the duty action and bits [3:2] are the period action. Address 1 is the duty value and address 2 is the period value. Address 3 is the command register: bit 0 enables, bit 1 disables and bit 2 restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register port |
| wrAddr | input | 2 | Register address (see R10) |
| wrData | input | CNT_W | Write data |
| clkSel | input | 2 | Prescaler divide select |
| syncIn | input | 1 | Shared restart for aligned channels |
| waveOut | output | 1 | Waveform output |
| dutyEvt | output | 1 | One-cycle pulse on a duty compare hit |
| periodEvt | output | 1 | One-cycle pulse on a period compare hit |

## Verification
Two situations are hard to reach from the ports: a restart that lands partway through a slow prescaler interval, and a stop that freezes the count in the middle of a period. The stimulus retriggers a divide-by-8 run a few clocks after a tick, then checks that the next tick waits a full eight clocks. It also stops a run with a combined enable-and-disable write, holds it stopped for forty clocks, and re-enables it. After the re-enable, the duty pulse must arrive exactly where the frozen count predicts. The sweep covers every duty value from 0 to one past the period limit, with all sixteen action pairs. This includes the coincident-hit case, which tests that the period action takes priority.

// File: rtl/cwt_pkg.sv
package cwt_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_SET    = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;

  typedef struct packed {
    logic restart;
    logic advance;
  } strobe_t;

  localparam logic [1:0] ADDR_ACTIONS = 2'd0;
  localparam logic [1:0] ADDR_DUTY    = 2'd1;
  localparam logic [1:0] ADDR_PERIOD  = 2'd2;
  localparam logic [1:0] ADDR_CMD     = 2'd3;

  localparam int CMD_EN_BIT   = 0;
  localparam int CMD_DIS_BIT  = 1;
  localparam int CMD_TRIG_BIT = 2;

  localparam int MAX_SHIFT = 5;
  localparam int PRE_W     = MAX_SHIFT;

  function automatic int unsigned selShift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 0;
      2'd1:    return 1;
      2'd2:    return 3;
      default: return MAX_SHIFT;
    endcase
  endfunction

  function automatic logic [PRE_W-1:0] selMask(input logic [1:0] sel);
    logic [PRE_W:0] one;
    one = (PRE_W+1)'(1) << selShift(sel);
    return PRE_W'(one - 1'b1);
  endfunction

  function automatic logic applyAct(input logic cur, input act_e act);
    case (act)
      ACT_SET:    return 1'b1;
      ACT_CLEAR:  return 1'b0;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/cwt_ctrl.sv
module cwt_ctrl
  import cwt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       clkSel,
  input  logic             syncIn,
  output strobe_t          strobe,
  output logic [CNT_W-1:0] dutyVal,
  output logic [CNT_W-1:0] periodVal,
  output act_e             dutyAct,
  output act_e             periodAct
);

  logic             running;
  logic             runNext;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] tickMask;
  logic             tick;
  logic             cmdHit;
  logic             enCmd;
  logic             disCmd;
  logic             trigCmd;

  always_comb begin
    cmdHit  = wrEn && (wrAddr == ADDR_CMD);
    enCmd   = cmdHit && wrData[CMD_EN_BIT];
    disCmd  = cmdHit && wrData[CMD_DIS_BIT];
    trigCmd = cmdHit && wrData[CMD_TRIG_BIT];
    if (disCmd)     runNext = 1'b0;
    else if (enCmd) runNext = 1'b1;
    else            runNext = running;
    tickMask       = selMask(clkSel);
    tick           = (preCnt & tickMask) == tickMask;
    strobe.restart = trigCmd || syncIn;
    strobe.advance = tick && runNext && !strobe.restart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      preCnt  <= '0;
    end else begin
      running <= runNext;
      if (strobe.restart) preCnt <= '0;
      else                preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyVal   <= '0;
      periodVal <= '0;
      dutyAct   <= ACT_NONE;
      periodAct <= ACT_NONE;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_ACTIONS: begin
          dutyAct   <= act_e'(wrData[1:0]);
          periodAct <= act_e'(wrData[3:2]);
        end
        ADDR_DUTY:   dutyVal   <= wrData;
        ADDR_PERIOD: periodVal <= wrData;
        default: ;
      endcase
    end
  end

  a_r9_disable_wins: assert property (@(posedge clk) disable iff (!rstN)
    disCmd |=> !running);
  a_r9_enable_runs: assert property (@(posedge clk) disable iff (!rstN)
    (enCmd && !disCmd) |=> running);
  a_r6_div1_ticks: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == 2'd0 && running && !disCmd && !strobe.restart) |-> strobe.advance);

endmodule

// File: rtl/cwt_datapath.sv
module cwt_datapath
  import cwt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [CNT_W-1:0] dutyVal,
  input  logic [CNT_W-1:0] periodVal,
  input  act_e             dutyAct,
  input  act_e             periodAct,
  output logic             waveOut,
  output logic             dutyEvt,
  output logic             periodEvt
);

  logic [CNT_W-1:0] cnt;
  logic             dutyHit;
  logic             periodHit;
  act_e             selAct;

  always_comb begin
    dutyHit   = strobe.advance && (cnt == dutyVal);
    periodHit = strobe.advance && (cnt == periodVal);
    if (periodHit)    selAct = periodAct;
    else if (dutyHit) selAct = dutyAct;
    else              selAct = ACT_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      waveOut   <= 1'b0;
      dutyEvt   <= 1'b0;
      periodEvt <= 1'b0;
    end else begin
      if (strobe.restart)     cnt <= '0;
      else if (periodHit)     cnt <= '0;
      else if (strobe.advance) cnt <= cnt + 1'b1;
      waveOut   <= applyAct(waveOut, selAct);
      dutyEvt   <= dutyHit;
      periodEvt <= periodHit;
    end
  end

  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    periodEvt |-> (cnt == '0));
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && cnt != periodVal) |=> (cnt == $past(cnt) + 1'b1));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !strobe.restart) |=> ($stable(cnt) && $stable(waveOut)));
  a_r3_evt_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    dutyEvt |-> $past(strobe.advance));
  a_r4_wave_moves_on_evt: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(waveOut) |-> (dutyEvt || periodEvt));
  a_r5_period_wins: assert property (@(posedge clk) disable iff (!rstN)
    (dutyEvt && periodEvt && $past(periodAct) == ACT_CLEAR) |-> !waveOut);
  a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (cnt == '0 && $stable(waveOut) && !dutyEvt && !periodEvt));

endmodule

// File: rtl/cmp_wave_timer.sv
module cmp_wave_timer
  import cwt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       clkSel,
  input  logic             syncIn,
  output logic             waveOut,
  output logic             dutyEvt,
  output logic             periodEvt
);

  strobe_t          strobe;
  logic [CNT_W-1:0] dutyVal;
  logic [CNT_W-1:0] periodVal;
  act_e             dutyAct;
  act_e             periodAct;

  cwt_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .clkSel    (clkSel),
    .syncIn    (syncIn),
    .strobe    (strobe),
    .dutyVal   (dutyVal),
    .periodVal (periodVal),
    .dutyAct   (dutyAct),
    .periodAct (periodAct)
  );

  cwt_datapath #(.CNT_W(CNT_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .dutyVal   (dutyVal),
    .periodVal (periodVal),
    .dutyAct   (dutyAct),
    .periodAct (periodAct),
    .waveOut   (waveOut),
    .dutyEvt   (dutyEvt),
    .periodEvt (periodEvt)
  );

endmodule

// File: tb/tb_cmp_wave_timer.sv
module tb_cmp_wave_timer;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [1:0]       wrAddr = '0;
  logic [CNT_W-1:0] wrData = '0;
  logic [1:0]       clkSel = '0;
  logic             syncIn = 1'b0;
  logic             waveOut;
  logic             dutyEvt;
  logic             periodEvt;

  int  total = 0;
  int  bad = 0;
  int  expWave = 0;
  int  cycles = 0;
  bit  finished = 0;

  always #4 clk = ~clk;

  cmp_wave_timer #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .clkSel(clkSel), .syncIn(syncIn), .waveOut(waveOut),
    .dutyEvt(dutyEvt), .periodEvt(periodEvt)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int benchAct(input int w, input int a);
    case (a)
      1: return 1;
      2: return 0;
      3: return 1 - w;
      default: return w;
    endcase
  endfunction

  task automatic wr(input int addr, input int data);
    wrEn = 1'b1; wrAddr = 2'(addr); wrData = CNT_W'(data);
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic configure(input int sel, input int ra, input int rc, input int raA, input int rcA);
    wr(0, (rcA << 2) | raA);
    wr(1, ra);
    wr(2, rc);
    clkSel = 2'(sel);
  endtask

  task automatic startRun(input bit viaSync);
    if (viaSync) begin
      syncIn = 1'b1;
      wr(3, 1);
      syncIn = 1'b0;
    end else begin
      wr(3, 5);
    end
  endtask

  // samples t = tFirst..tLast edges after the restart edge
  task automatic checkRun(input int sel, input int ra, input int rc, input int raA,
                          input int rcA, input int tFirst, input int tLast,
                          input bit waitFirst, input string tagOverride);
    int n;
    n = 1 << ((sel == 0) ? 0 : (sel == 1) ? 1 : (sel == 2) ? 3 : 5);
    for (int t = tFirst; t <= tLast; t++) begin
      int expRa, expRc, v;
      string tagW, tagRc, tagRa;
      if (t != tFirst || waitFirst) begin
        @(posedge clk); #1;
      end
      expRa = 0; expRc = 0;
      if (t % n == 0) begin
        v = ((t / n) - 1) % (rc + 1);
        expRa = (v == ra) ? 1 : 0;
        expRc = (v == rc) ? 1 : 0;
        if (expRc != 0)      expWave = benchAct(expWave, rcA);
        else if (expRa != 0) expWave = benchAct(expWave, raA);
      end
      tagRc = (tagOverride != "") ? tagOverride : (sel != 0) ? "R6" : "R2";
      tagRa = (tagOverride != "") ? tagOverride : "R3";
      tagW  = (tagOverride != "") ? tagOverride : (ra == rc) ? "R5" : "R4";
      chk(tagRc, "periodEvt", int'(periodEvt), expRc);
      chk(tagRa, "dutyEvt", int'(dutyEvt), expRa);
      chk(tagW, "waveOut", int'(waveOut), expWave);
    end
  endtask

  task automatic checkQuiet(input string req, input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      chk(req, "dutyEvt quiet", int'(dutyEvt), 0);
      chk(req, "periodEvt quiet", int'(periodEvt), 0);
      chk(req, "waveOut held", int'(waveOut), expWave);
    end
  endtask

  initial begin
    while (!finished && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rcList[3];
    rcList[0] = 0; rcList[1] = 2; rcList[2] = 5;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state and no activity without enable
    chk("R1", "waveOut after reset", int'(waveOut), 0);
    checkQuiet("R1", 20);
    // R10: program registers but do not enable
    configure(0, 0, 0, 3, 3);
    checkQuiet("R1", 20);

    // R7: restart while stopped gives no events
    configure(0, 1, 3, 3, 3);
    wr(3, 4);
    checkQuiet("R7", 30);

    // main sweep (R2..R6, R8, R10)
    for (int sel = 0; sel < 4; sel++) begin
      for (int ri = 0; ri < 3; ri++) begin
        int rc, n;
        rc = rcList[ri];
        n = 1 << ((sel == 0) ? 0 : (sel == 1) ? 1 : (sel == 2) ? 3 : 5);
        for (int ra = 0; ra <= rc + 1; ra++) begin
          for (int raA = 0; raA < 4; raA++) begin
            for (int rcA = 0; rcA < 4; rcA++) begin
              if (sel != 0 && !(raA == 2 && rcA == 1)) continue;
              configure(sel, ra, rc, raA, rcA);
              startRun(sel == 1);
              checkRun(sel, ra, rc, raA, rcA, 1, n * (rc + 1) * 3 + 2, 1'b1,
                       (sel == 1) ? "R8" : "");
              wr(3, 2);
            end
          end
        end
      end
    end

    // R7: retrigger partway through a divide-by-8 interval
    configure(2, 1, 3, 3, 0);
    startRun(1'b0);
    checkRun(2, 1, 3, 3, 0, 1, 13, 1'b1, "R7");
    wr(3, 4);
    chk("R7", "waveOut unchanged by restart", int'(waveOut), expWave);
    checkRun(2, 1, 3, 3, 0, 1, 70, 1'b1, "R7");
    wr(3, 2);

    // R9: halt with enable+disable together, hold, then resume
    configure(0, 4, 9, 3, 0);
    startRun(1'b0);
    checkRun(0, 4, 9, 3, 0, 1, 3, 1'b1, "R9");
    wr(3, 3);
    checkQuiet("R9", 40);
    wr(3, 1);
    checkRun(0, 4, 9, 3, 0, 4, 40, 1'b0, "R9");
    wr(3, 2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule